// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the combinational arithmetic and logic unit of a three-operand RISC integer datapath. On every input change it produces a 32-bit result from two operands, a 16-bit immediate, a 5-bit shift field and an operation code. The second operand comes either from the register path or from the immediate. The immediate is extended inside the block: sign extension for arithmetic and compare operations, zero extension for bitwise operations.

Addition and subtraction come in two forms. The trapping form raises an overflow flag on two's-complement overflow. The wrapping form never raises it. Both forms give the same result bits. When the flag is raised, a write-suppress output tells the surrounding datapath not to commit the destination register. The block does not write the register file and does not handle the exception.

Top module: `alu32_trap`

## Requirements
- R1: Codes ADD=0, ADDU=1, SUB=2, SUBU=3 return op_a plus or minus the second operand, modulo 2^32.
- R2: ovf is 1 only for ADD (0) or SUB (2), and only when the signed result overflows. It is always 0 for ADDU and SUBU.
- R3: wr_suppress is 1 exactly when ovf is 1.
- R4: When use_imm is 1, the 16-bit imm is sign-extended to form the second operand of ADD, ADDU, SUB, SUBU, SLT (8) and SLTU (9).
- R5: AND=4, OR=5, XOR=6 and NOR=7 are bitwise operations. When use_imm is 1, imm is zero-extended to form the second operand.
- R6: SLT returns 1 when op_a is less than the second operand as signed values, and SLTU does the same comparison as unsigned values. Otherwise each returns 0. Bits 31..1 are always 0.
- R7: LUI (10) returns imm in bits 31..16 and zeros in bits 15..0.
- R8: SLL=11, SRL=12 and SRA=13 shift op_b by shamt. SLL and SRL fill vacated bits with 0, and SRA fills them with op_b bit 31.
- R9: SLLV=14, SRLV=15 and SRAV=16 shift op_b the same way as R8, but the amount is op_a bits 4..0. The upper bits of op_a are ignored.
- R10: Codes 17 to 31 return 0 with ovf and wr_suppress low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| op_a | input | 32 | First operand; also the register shift amount |
| op_b | input | 32 | Register-path second operand; the value shifted by shift ops |
| imm | input | 16 | Instruction immediate |
| use_imm | input | 1 | Selects the extended immediate as the second operand |
| shamt | input | 5 | Shift amount from the instruction field |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow on a trapping add or subtract |
| wr_suppress | output | 1 | Tells the datapath to skip the destination write |

## Verification
The bound checker evaluates on every input change that the overflow and suppress flags appear only for the trapping codes and always agree with each other. It also checks that set-less-than returns a single bit, that the load-upper result has a clear low half, that unassigned codes return zero, and that a trapping register add with overflow has flipped the sign. Exact values need the bench's scenarios: wrap-around at the signed limits, immediate sign versus zero extension, fill bits at shift extremes, masking of the register shift amount, and signed versus unsigned ordering of the same bit patterns.

// File: rtl/alu32_pkg.sv
// Package: shared operation codes for the integer ALU.
// Assumes a 5-bit operation field; codes above SRAV are unassigned.
package alu32_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_LUI  = 5'd10,
        OP_SLL  = 5'd11,
        OP_SRL  = 5'd12,
        OP_SRA  = 5'd13,
        OP_SLLV = 5'd14,
        OP_SRLV = 5'd15,
        OP_SRAV = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/alu_operand_sel.sv
// Module: second-operand selection with immediate extension.
// Assumes IMM_W < WIDTH. zext chooses zero extension; otherwise sign extension.
module alu_operand_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] reg_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic             zext,
    output logic [WIDTH-1:0] operand
);
    localparam int PAD = WIDTH - IMM_W;

    logic [WIDTH-1:0] imm_ext;

    // Extend the immediate with zeros or copies of its sign bit.
    always_comb begin
        if (zext) imm_ext = {{PAD{1'b0}}, imm};
        else      imm_ext = {{PAD{imm[IMM_W-1]}}, imm};
    end

    // Pick the register value or the extended immediate.
    always_comb operand = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/alu_addsub.sv
// Module: shared adder/subtractor with signed overflow detection.
// Assumes two's-complement operands; overflow is reported for every use, and the caller decides whether it traps.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             sgn_ovf
);
    logic [WIDTH-1:0] b_eff;

    // Invert the second operand for subtraction; the carry-in completes the negation.
    always_comb b_eff = sub ? ~b : b;

    // Form the sum and flag a sign flip when both addends have the same sign.
    always_comb begin
        sum     = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
        sgn_ovf = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
// Module: logarithmic barrel shifter for left, logical-right and arithmetic-right shifts.
// Assumes WIDTH is a power of two; left shifts reuse the right-shift stages on a bit-reversed value.
module alu_shifter
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SHW-1:0]   amt,
    input  shift_kind_e      kind,
    output logic [WIDTH-1:0] shifted
);
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stage [SHW+1];
    logic             fill;

    // Reverse the bit order of the input and the output for left shifts.
    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign rev_in[k]  = value[WIDTH-1-k];
        assign rev_out[k] = stage[SHW][WIDTH-1-k];
    end

    // Choose the stage input and the fill bit for this kind of shift.
    always_comb begin
        stage[0] = (kind == SH_LEFT) ? rev_in : value;
        fill     = (kind == SH_RARI) & value[WIDTH-1];
    end

    // Each stage shifts right by a power of two when its amount bit is set.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][WIDTH-1:STEP]} : stage[i];
    end

    // Undo the reversal for left shifts.
    always_comb shifted = (kind == SH_LEFT) ? rev_out : stage[SHW];
endmodule

// File: rtl/alu32_trap.sv
// Module: combinational integer ALU with a trapping add/subtract overflow flag.
// Assumes the datapath treats wr_suppress as a veto on the destination write.
// Unassigned codes give zero.
module alu32_trap
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             ovf,
    output logic             wr_suppress
);
    alu_op_e          opc;
    logic             is_logic;
    logic             is_sub;
    logic             is_trap;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] sum;
    logic             sgn_ovf;
    logic [SHW-1:0]   sh_amt;
    shift_kind_e      sh_kind;
    logic [WIDTH-1:0] sh_out;

    // Decode the opcode into control lines.
    always_comb begin
        opc      = alu_op_e'(op);
        is_logic = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR) || (opc == OP_NOR);
        is_sub   = (opc == OP_SUB) || (opc == OP_SUBU);
        is_trap  = (opc == OP_ADD) || (opc == OP_SUB);
    end

    // Select the shift amount source and the kind of shift.
    always_comb begin
        sh_amt = ((opc == OP_SLLV) || (opc == OP_SRLV) || (opc == OP_SRAV)) ? op_a[SHW-1:0] : shamt;
        unique case (opc)
            OP_SRL, OP_SRLV: sh_kind = SH_RLOG;
            OP_SRA, OP_SRAV: sh_kind = SH_RARI;
            default:         sh_kind = SH_LEFT;
        endcase
    end

    alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .reg_val (op_b),
        .imm     (imm),
        .use_imm (use_imm),
        .zext    (is_logic),
        .operand (opnd_b)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a       (op_a),
        .b       (opnd_b),
        .sub     (is_sub),
        .sum     (sum),
        .sgn_ovf (sgn_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .value   (op_b),
        .amt     (sh_amt),
        .kind    (sh_kind),
        .shifted (sh_out)
    );

    // Steer the unit output selected by the opcode onto the result.
    always_comb begin
        result = '0;
        case (opc)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
            OP_AND:  result = op_a & opnd_b;
            OP_OR:   result = op_a | opnd_b;
            OP_XOR:  result = op_a ^ opnd_b;
            OP_NOR:  result = ~(op_a | opnd_b);
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(opnd_b))};
            OP_SLTU: result = {{(WIDTH-1){1'b0}}, (op_a < opnd_b)};
            OP_LUI:  result = {imm, {(WIDTH-IMM_W){1'b0}}};
            OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result = sh_out;
            default: result = '0;
        endcase
    end

    // Raise the trap only for the trapping codes, and veto the write with it.
    always_comb begin
        ovf         = is_trap & sgn_ovf;
        wr_suppress = ovf;
    end
endmodule

// File: rtl/alu32_trap_checker.sv
// Module: property checker bound to the ALU.
// Evaluates immediate assertions whenever the combinational inputs or outputs change.
module alu32_trap_checker
    import alu32_pkg::*;
(
    input logic [OP_W-1:0] op,
    input logic [31:0]     op_a,
    input logic            use_imm,
    input logic [15:0]     imm,
    input logic [31:0]     result,
    input logic            ovf,
    input logic            wr_suppress
);
    // Check the output relations for the current operation.
    always_comb begin
        assert_no_overflow_R2: assert (!ovf || op == OP_ADD || op == OP_SUB)
            else $error("ovf on non-trapping code %0d", op);
        assert_suppress_match_R3: assert (wr_suppress == ovf)
            else $error("wr_suppress %0b ovf %0b", wr_suppress, ovf);
        assert_suppress_trap_R3: assert (!wr_suppress || op == OP_ADD || op == OP_SUB)
            else $error("write vetoed on code %0d", op);
        assert_add_sign_R2: assert (!(op == OP_ADD && !use_imm && ovf) || (result[31] != op_a[31]))
            else $error("overflow without sign flip");
        assert_slt_bit_R6: assert (!(op == OP_SLT || op == OP_SLTU) || result[31:1] == '0)
            else $error("compare result %h", result);
        assert_lui_low_R7: assert (op != OP_LUI || (result[15:0] == '0 && result[31:16] == imm))
            else $error("lui result %h", result);
        assert_unassigned_R10: assert (op <= OP_SRAV || (result == '0 && !ovf))
            else $error("unassigned code %0d result %h", op, result);
    end
endmodule

bind alu32_trap alu32_trap_checker u_chk (
    .op          (op),
    .op_a        (op_a),
    .use_imm     (use_imm),
    .imm         (imm),
    .result      (result),
    .ovf         (ovf),
    .wr_suppress (wr_suppress)
);

// File: tb/alu32_trap_bench.sv
// Bench: scoreboard test of the integer ALU. A driver task applies inputs on the rising edge and queues the expected output.
// A monitor takes one queued item per falling edge and compares it with the outputs.
module alu32_trap_bench;
    import alu32_pkg::*;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf;
    logic        wr_suppress;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    alu32_trap u_alu32_trap (
        .op          (op),
        .op_a        (op_a),
        .op_b        (op_b),
        .imm         (imm),
        .use_imm     (use_imm),
        .shamt       (shamt),
        .result      (result),
        .ovf         (ovf),
        .wr_suppress (wr_suppress)
    );

    // Apply one set of inputs on the rising edge and queue its expected output.
    task automatic drive(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic ui, input logic [4:0] sh,
                         input logic [31:0] er, input logic eo, input string tag);
        exp_t e;
        @(posedge clk);
        op = o; op_a = a; op_b = b; imm = im; use_imm = ui; shamt = sh;
        e.res = er; e.ovf = eo; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Compare the outputs with the oldest queued item on each falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (result !== e.res || ovf !== e.ovf || wr_suppress !== e.ovf) begin
                errors++;
                $display("FAIL %s: result=%h ovf=%b sup=%b expected result=%h ovf=%b sup=%b",
                         e.tag, result, ovf, wr_suppress, e.res, e.ovf, e.ovf);
            end
        end
    end

    // Stop a hung run and count it as a failed check.
    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Run the scenarios.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle inputs give a zero sum and no flags
        drive(OP_ADD, 32'h0, 32'h0, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R1 zero add");
        drive(OP_SUB, 32'd5, 32'd7, 16'h0, 1'b0, 5'd0, 32'hFFFF_FFFE, 1'b0, "R1 sub borrow");
        // R2/R3: trapping and wrapping forms at the signed limits
        drive(OP_ADD,  32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h8000_0000, 1'b1, "R2 add overflow");
        drive(OP_ADDU, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h8000_0000, 1'b0, "R2 addu no trap");
        drive(OP_SUB,  32'h8000_0000, 32'd1, 16'h0, 1'b0, 5'd0, 32'h7FFF_FFFF, 1'b1, "R3 sub overflow suppress");
        drive(OP_SUBU, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 5'd0, 32'h7FFF_FFFF, 1'b0, "R2 subu no trap");
        drive(OP_SUB,  32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd0, 32'h8000_0000, 1'b1, "R2 sub min");
        drive(OP_ADD,  32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'h0, 1'b0, "R2 add carry no overflow");
        // R4: sign-extended immediates
        drive(OP_ADD, 32'd10, 32'hDEAD_BEEF, 16'hFFFE, 1'b1, 5'd0, 32'd8, 1'b0, "R4 add neg imm");
        drive(OP_ADD, 32'h7FFF_FFFF, 32'h0, 16'h0001, 1'b1, 5'd0, 32'h8000_0000, 1'b1, "R4 add imm overflow");
        drive(OP_SLT, 32'hFFFF_FFFB, 32'h0, 16'hFFFE, 1'b1, 5'd0, 32'd1, 1'b0, "R4 slt neg imm");
        // R5: zero-extended logical immediates and register forms
        drive(OP_AND, 32'hFFFF_FFFF, 32'h0, 16'h8001, 1'b1, 5'd0, 32'h0000_8001, 1'b0, "R5 and imm");
        drive(OP_OR,  32'h0, 32'h0, 16'hF000, 1'b1, 5'd0, 32'h0000_F000, 1'b0, "R5 or imm");
        drive(OP_XOR, 32'hFFFF_0000, 32'h0, 16'h00FF, 1'b1, 5'd0, 32'hFFFF_00FF, 1'b0, "R5 xor imm");
        drive(OP_NOR, 32'h0F0F_0F0F, 32'h00FF_00FF, 16'h0, 1'b0, 5'd0, 32'hF000_F000, 1'b0, "R5 nor reg");
        // R6: signed versus unsigned ordering
        drive(OP_SLT,  32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'd1, 1'b0, "R6 slt -1<1");
        drive(OP_SLTU, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, 32'd0, 1'b0, "R6 sltu big");
        drive(OP_SLT,  32'd3, 32'd3, 16'h0, 1'b0, 5'd0, 32'd0, 1'b0, "R6 slt equal");
        drive(OP_SLTU, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, 32'd1, 1'b0, "R6 sltu small");
        // R7: load-upper
        drive(OP_LUI, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 1'b0, 5'd7, 32'hABCD_0000, 1'b0, "R7 lui");
        // R8: field-amount shifts
        drive(OP_SLL, 32'h0, 32'h8000_0001, 16'h0, 1'b0, 5'd4,  32'h0000_0010, 1'b0, "R8 sll");
        drive(OP_SRL, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd31, 32'h0000_0001, 1'b0, "R8 srl 31");
        drive(OP_SRA, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd4,  32'hF800_0000, 1'b0, "R8 sra neg");
        drive(OP_SRA, 32'h0, 32'h4000_0000, 16'h0, 1'b0, 5'd30, 32'h0000_0001, 1'b0, "R8 sra pos");
        drive(OP_SLL, 32'h0, 32'h1234_5678, 16'h0, 1'b0, 5'd0,  32'h1234_5678, 1'b0, "R8 shift zero");
        // R9: register-amount shifts with masked upper bits
        drive(OP_SLLV, 32'hFFFF_FFE3, 32'd1, 16'h0, 1'b0, 5'd9, 32'd8, 1'b0, "R9 sllv");
        drive(OP_SRAV, 32'hFFFF_FFE1, 32'h8000_0000, 16'h0, 1'b0, 5'd0, 32'hC000_0000, 1'b0, "R9 srav");
        drive(OP_SRLV, 32'h0000_0024, 32'hF000_0000, 16'h0, 1'b0, 5'd0, 32'h0F00_0000, 1'b0, "R9 srlv");
        // R10: unassigned codes
        drive(5'd17, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 1'b0, 5'd3, 32'h0, 1'b0, "R10 code 17");
        drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd31, 32'h0, 1'b0, "R10 code 31");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule